// File: doc/BRIEF.md
# Banked General Register File with Shadow Sets

This block is the general-purpose register store of a pipelined processor core. Each bank holds 32 registers of 32 bits. The block keeps several complete copies of that bank, called shadow sets, so that a high-priority interrupt handler can run in a fresh set of registers without saving any state in software. The pipeline sees one write port and two combinational read ports, all aimed at the currently active set. A third read path and a second write path reach the previously active set. These carry the move-from-previous-set and move-to-previous-set operations.

Two 4-bit selectors are kept in the block: the current set and the previous set. An interrupt switch strobe carries a requested set number. On that strobe the current set moves to the requested set, and the number it held moves into the previous-set selector. A return strobe copies the previous set back into the current set. Deciding when to raise these strobes is the job of the surrounding logic. The number of sets is a parameter: 2 for a small configuration, 8 for a large one.

Top module: `shadow_gpr_file`

## Requirements
- R1: Pipeline reads on ports A and B are combinational and come from the current set. A pipeline write with `wr_en` high lands in the current set at the next rising clock edge and can be read from then on.
- R2: Register index 0 reads as 0 on every read path. A write to index 0 from any write path is discarded.
- R3: When `wr_link` is high, the pipeline write goes to register 31 of the current set, whatever value `wr_idx` holds. Register `wr_idx` is left unchanged.
- R4: Each set is an independent bank. A write into one set leaves every other set unchanged. The set count `NUM_SETS` is a parameter, 2 by default.
- R5: On the clock edge where `irq_switch` is high, `cur_set` takes `irq_set` and `prev_set` takes the old value of `cur_set`. Reads made after that edge come from the new set.
- R6: On the clock edge where `ret_restore` is high and `irq_switch` is low, `cur_set` takes `prev_set` and `prev_set` is unchanged. If both strobes are high in the same cycle, the switch is performed and the return is ignored.
- R7: The cross-bank read port `xb_rd_*` reads the set named by `prev_set`. The cross-bank write `xb_wr_*` writes into that set at the next edge.
- R8: A read of the register being written, in the same set and the same cycle, returns the data being written. If the pipeline write and the cross-bank write hit the same register of the same set, the pipeline data wins, both in the bypass and in storage.
- R9: An `irq_set` value of `NUM_SETS` or more selects set 0.
- R10: A synchronous active-low reset sets `cur_set` and `prev_set` to 0 and clears every register of every set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Pipeline read port A register index |
| rd_a_data | output | 32 | Pipeline read port A data |
| rd_b_idx | input | 5 | Pipeline read port B register index |
| rd_b_data | output | 32 | Pipeline read port B data |
| wr_en | input | 1 | Pipeline write enable |
| wr_link | input | 1 | Pipeline write aimed at register 31 (return address) |
| wr_idx | input | 5 | Pipeline write register index |
| wr_data | input | 32 | Pipeline write data |
| irq_switch | input | 1 | Interrupt entry strobe requesting a set switch |
| irq_set | input | 4 | Set number requested by the interrupt |
| ret_restore | input | 1 | Return strobe restoring the previous set |
| xb_rd_idx | input | 5 | Cross-bank read register index |
| xb_rd_data | output | 32 | Cross-bank read data from the previous set |
| xb_wr_en | input | 1 | Cross-bank write enable |
| xb_wr_idx | input | 5 | Cross-bank write register index |
| xb_wr_data | input | 32 | Cross-bank write data |
| cur_set | output | 4 | Currently active set |
| prev_set | output | 4 | Previous set selector |

## Verification
Read data is due in the same cycle as the index, so it is checked 2 ns after the inputs change. This is well before the next rising edge. Writes and the set selectors change at one rising edge, so their effect is checked 2 ns after the following falling edge, one cycle after the stimulus. The driver task queues each expected value only after the stimulus for that cycle has been applied. The monitor compares the value in that same settled window, so no check can fall across a clock edge.

// File: rtl/sgpr_pkg.sv
// Shared widths and types for the banked register file.
// Assumes set selectors are always 4 bits wide, independent of set count.
package sgpr_pkg;
    localparam int SEL_W = 4;
    typedef logic [SEL_W-1:0] set_num_t;
endpackage

// File: rtl/sgpr_set_ctrl.sv
// Current/previous set selectors. Switch strobe has priority over return.
// Assumes NUM_SETS is at most 16 so every set number fits the selector.
module sgpr_set_ctrl
    import sgpr_pkg::*;
#(
    parameter int NUM_SETS = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     irq_switch,
    input  set_num_t irq_set,
    input  logic     ret_restore,
    output set_num_t cur_set,
    output set_num_t prev_set
);
    localparam logic [SEL_W:0] SET_LIM = (SEL_W+1)'(NUM_SETS);

    set_num_t req_set;

    // Fold an out-of-range request back to set 0.
    always_comb begin
        req_set = ({1'b0, irq_set} < SET_LIM) ? irq_set : '0;
    end

    // Update selectors on interrupt entry or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_set  <= '0;
            prev_set <= '0;
        end else if (irq_switch) begin
            cur_set  <= req_set;
            prev_set <= cur_set;
        end else if (ret_restore) begin
            cur_set  <= prev_set;
        end
    end

    AST_SWITCH_SAVES_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        irq_switch |=> (prev_set == $past(cur_set))); // R5
    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_restore && !irq_switch) |=> (cur_set == $past(prev_set))); // R6
    AST_SET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cur_set} < SET_LIM); // R9
    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_switch && !ret_restore) |=> $stable(cur_set)); // R5
endmodule

// File: rtl/sgpr_bank_array.sv
// Storage for all sets. Port P writes the current set, port X the previous
// set; P wins on collision. Entry 0 of each set is a constant zero.
module sgpr_bank_array
    import sgpr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int NUM_SETS = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  set_num_t          cur_set,
    input  set_num_t          prev_set,
    input  logic              p_we,
    input  logic [IDX_W-1:0]  p_idx,
    input  logic [DATA_W-1:0] p_data,
    input  logic              x_we,
    input  logic [IDX_W-1:0]  x_idx,
    input  logic [DATA_W-1:0] x_data,
    output logic [DATA_W-1:0] mem_q [NUM_SETS][NUM_REGS]
);
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            if (r == 0) begin : g_zero
                assign mem_q[s][r] = '0;
            end else begin : g_store
                logic p_hit, x_hit;
                assign p_hit = p_we && (cur_set == SEL_W'(s)) && (p_idx == IDX_W'(r));
                assign x_hit = x_we && (prev_set == SEL_W'(s)) && (x_idx == IDX_W'(r));
                // Capture one entry, pipeline port first.
                always_ff @(posedge clk) begin
                    if (!rst_n)     mem_q[s][r] <= '0;
                    else if (p_hit) mem_q[s][r] <= p_data;
                    else if (x_hit) mem_q[s][r] <= x_data;
                end
            end
        end
    end
endmodule

// File: rtl/sgpr_read_port.sv
// One combinational read path with zero-register forcing and write bypass.
// Assumes rd_set is below NUM_SETS and NUM_SETS is a power of two.
module sgpr_read_port
    import sgpr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int NUM_SETS = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [DATA_W-1:0] mem_q [NUM_SETS][NUM_REGS],
    input  set_num_t          rd_set,
    input  logic [IDX_W-1:0]  rd_idx,
    input  set_num_t          cur_set,
    input  set_num_t          prev_set,
    input  logic              p_we,
    input  logic [IDX_W-1:0]  p_idx,
    input  logic [DATA_W-1:0] p_data,
    input  logic              x_we,
    input  logic [IDX_W-1:0]  x_idx,
    input  logic [DATA_W-1:0] x_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BANK_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

    // Select zero, bypassed write data, or stored value.
    always_comb begin
        if (rd_idx == '0)
            rd_data = '0;
        else if (p_we && rd_set == cur_set && rd_idx == p_idx)
            rd_data = p_data;
        else if (x_we && rd_set == prev_set && rd_idx == x_idx)
            rd_data = x_data;
        else
            rd_data = mem_q[rd_set[BANK_W-1:0]][rd_idx];
    end
endmodule

// File: rtl/shadow_gpr_file.sv
// Banked general register file: two pipeline reads and one pipeline write
// on the current set, one read and one write on the previous set.
// Assumes strobes come from external control, one cycle wide.
module shadow_gpr_file
    import sgpr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int NUM_SETS = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic              wr_link,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_switch,
    input  logic [SEL_W-1:0]  irq_set,
    input  logic              ret_restore,
    input  logic [IDX_W-1:0]  xb_rd_idx,
    output logic [DATA_W-1:0] xb_rd_data,
    input  logic              xb_wr_en,
    input  logic [IDX_W-1:0]  xb_wr_idx,
    input  logic [DATA_W-1:0] xb_wr_data,
    output logic [SEL_W-1:0]  cur_set,
    output logic [SEL_W-1:0]  prev_set
);
    localparam int NUM_RP = 3;
    localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(NUM_REGS - 1);

    logic              p_we;
    logic [IDX_W-1:0]  p_idx;
    logic [DATA_W-1:0] mem_q [NUM_SETS][NUM_REGS];
    set_num_t          rp_set  [NUM_RP];
    logic [IDX_W-1:0]  rp_idx  [NUM_RP];
    logic [DATA_W-1:0] rp_data [NUM_RP];

    // Steer link writes to the return-address register.
    always_comb begin
        p_we  = wr_en || wr_link;
        p_idx = wr_link ? LINK_IDX : wr_idx;
    end

    sgpr_set_ctrl #(.NUM_SETS(NUM_SETS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_switch(irq_switch), .irq_set(irq_set),
        .ret_restore(ret_restore), .cur_set(cur_set), .prev_set(prev_set)
    );

    sgpr_bank_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SETS(NUM_SETS),
                      .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .cur_set(cur_set), .prev_set(prev_set),
        .p_we(p_we), .p_idx(p_idx), .p_data(wr_data),
        .x_we(xb_wr_en), .x_idx(xb_wr_idx), .x_data(xb_wr_data), .mem_q(mem_q)
    );

    // Route port selections: A and B on the current set, X on the previous.
    always_comb begin
        rp_set[0] = cur_set;  rp_idx[0] = rd_a_idx;
        rp_set[1] = cur_set;  rp_idx[1] = rd_b_idx;
        rp_set[2] = prev_set; rp_idx[2] = xb_rd_idx;
    end

    for (genvar p = 0; p < NUM_RP; p++) begin : g_rp
        sgpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SETS(NUM_SETS),
                         .IDX_W(IDX_W)) u_rp (
            .mem_q(mem_q), .rd_set(rp_set[p]), .rd_idx(rp_idx[p]),
            .cur_set(cur_set), .prev_set(prev_set),
            .p_we(p_we), .p_idx(p_idx), .p_data(wr_data),
            .x_we(xb_wr_en), .x_idx(xb_wr_idx), .x_data(xb_wr_data),
            .rd_data(rp_data[p])
        );
    end

    assign rd_a_data  = rp_data[0];
    assign rd_b_data  = rp_data[1];
    assign xb_rd_data = rp_data[2];

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0)); // R2
    AST_ZERO_REG_X: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_rd_idx == '0) |-> (xb_rd_data == '0)); // R2
    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_link && wr_idx != '0 && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data)); // R8
    AST_LINK_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_link && rd_b_idx == LINK_IDX) |-> (rd_b_data == wr_data)); // R3
endmodule

// File: tb/shadow_gpr_file_test.sv
`timescale 1ns/1ps
module shadow_gpr_file_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, xb_rd_idx = '0, xb_wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, xb_rd_data, wr_data = '0, xb_wr_data = '0;
    logic        wr_en = 1'b0, wr_link = 1'b0, irq_switch = 1'b0, ret_restore = 1'b0, xb_wr_en = 1'b0;
    logic [3:0]  irq_set = '0, cur_set, prev_set;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct { string tag; int sel; logic [31:0] exp; } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    shadow_gpr_file uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_link(wr_link), .wr_idx(wr_idx), .wr_data(wr_data),
        .irq_switch(irq_switch), .irq_set(irq_set), .ret_restore(ret_restore),
        .xb_rd_idx(xb_rd_idx), .xb_rd_data(xb_rd_data),
        .xb_wr_en(xb_wr_en), .xb_wr_idx(xb_wr_idx), .xb_wr_data(xb_wr_data),
        .cur_set(cur_set), .prev_set(prev_set)
    );

    // Monitor: pops expected items and compares against the named output.
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb.size() != 0);
            it = sb.pop_front();
            case (it.sel)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = xb_rd_data;
                3: act = {28'b0, cur_set};
                default: act = {28'b0, prev_set};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fails++;
                $display("FAIL %s: port %0d actual %h expected %h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // Driver side: queue one expectation and wait for the monitor.
    task automatic expect_out(input string tag, input int sel, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb.push_back(it);
        wait (sb.size() == 0);
        #0.1;
    endtask

    // Advance to the next falling edge and clear all strobes.
    task automatic next_cycle();
        @(negedge clk);
        wr_en = 0; wr_link = 0; xb_wr_en = 0; irq_switch = 0; ret_restore = 0;
    endtask

    task automatic settle();
        #2;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        rd_a_idx = 5; xb_rd_idx = 7; #1;
        expect_out("R10 cur after reset", 3, 0);
        expect_out("R10 prev after reset", 4, 0);
        expect_out("R10 reg cleared", 0, 0);
        expect_out("R10 xb reg cleared", 2, 0);

        // Same-cycle write and read, then stored value
        next_cycle(); wr_en = 1; wr_idx = 5; wr_data = 32'hA5A5_0001; rd_a_idx = 5; rd_b_idx = 5; settle();
        expect_out("R8 bypass A", 0, 32'hA5A5_0001);
        next_cycle(); settle();
        expect_out("R1 stored A", 0, 32'hA5A5_0001);
        expect_out("R1 stored B", 1, 32'hA5A5_0001);

        // Register zero
        next_cycle(); wr_en = 1; wr_idx = 0; wr_data = 32'hFFFF_FFFF; rd_a_idx = 0; settle();
        expect_out("R2 zero during write", 0, 0);
        next_cycle(); settle();
        expect_out("R2 zero after write", 0, 0);

        // Link write goes to r31
        next_cycle(); wr_link = 1; wr_idx = 3; wr_data = 32'h0000_1234; settle();
        next_cycle(); rd_a_idx = 31; rd_b_idx = 3; settle();
        expect_out("R3 r31 written", 0, 32'h0000_1234);
        expect_out("R3 named reg untouched", 1, 0);

        // Switch to set 1
        next_cycle(); irq_switch = 1; irq_set = 1; settle();
        next_cycle(); rd_a_idx = 5; xb_rd_idx = 5; settle();
        expect_out("R5 cur switched", 3, 1);
        expect_out("R5 prev saved", 4, 0);
        expect_out("R4 new set empty", 0, 0);
        expect_out("R7 xb reads prev set", 2, 32'hA5A5_0001);

        next_cycle(); wr_en = 1; wr_idx = 5; wr_data = 32'h0000_0011; settle();
        next_cycle(); settle();
        expect_out("R4 set1 value", 0, 32'h0000_0011);
        expect_out("R4 set0 unchanged", 2, 32'hA5A5_0001);

        // Cross-bank write into set 0
        next_cycle(); xb_wr_en = 1; xb_wr_idx = 6; xb_wr_data = 32'h0000_0066; settle();
        next_cycle(); xb_rd_idx = 6; rd_a_idx = 6; settle();
        expect_out("R7 xb write landed", 2, 32'h0000_0066);
        expect_out("R7 current set untouched", 0, 0);
        next_cycle(); xb_wr_en = 1; xb_wr_idx = 7; xb_wr_data = 32'h0000_0077; xb_rd_idx = 7; settle();
        expect_out("R8 xb bypass", 2, 32'h0000_0077);

        // Return to set 0
        next_cycle(); ret_restore = 1; settle();
        next_cycle(); rd_a_idx = 6; rd_b_idx = 5; settle();
        expect_out("R6 cur restored", 3, 0);
        expect_out("R6 prev kept", 4, 0);
        expect_out("R6 set0 r6", 0, 32'h0000_0066);
        expect_out("R6 set0 r5", 1, 32'hA5A5_0001);

        // Wrap of out-of-range request
        next_cycle(); irq_switch = 1; irq_set = 1; settle();
        next_cycle(); irq_switch = 1; irq_set = 5; settle();
        next_cycle(); xb_rd_idx = 5; settle();
        expect_out("R9 wrapped to 0", 3, 0);
        expect_out("R9 prev is 1", 4, 1);
        expect_out("R9 xb reads set1", 2, 32'h0000_0011);
        next_cycle(); irq_switch = 1; irq_set = 2; settle();
        next_cycle(); settle();
        expect_out("R9 boundary wraps", 3, 0);

        // Switch beats return in the same cycle (cur=0, prev=0 now)
        next_cycle(); irq_switch = 1; irq_set = 1; settle();
        next_cycle(); irq_switch = 1; irq_set = 0; ret_restore = 1; settle();
        next_cycle(); settle();
        expect_out("R6 switch wins cur", 3, 0);
        expect_out("R6 switch wins prev", 4, 1);

        // Collision with cur == prev
        next_cycle(); irq_switch = 1; irq_set = 1; settle();
        next_cycle(); irq_switch = 1; irq_set = 1; settle();
        next_cycle(); wr_en = 1; wr_idx = 9; wr_data = 32'h0000_00AA;
        xb_wr_en = 1; xb_wr_idx = 9; xb_wr_data = 32'h0000_00BB; rd_a_idx = 9; xb_rd_idx = 9; settle();
        expect_out("R8 collision bypass A", 0, 32'h0000_00AA);
        expect_out("R8 collision bypass X", 2, 32'h0000_00AA);
        next_cycle(); settle();
        expect_out("R8 collision stored", 0, 32'h0000_00AA);

        // Reset mid-run
        next_cycle(); rst_n = 0;
        next_cycle(); rst_n = 1; rd_a_idx = 9; settle();
        expect_out("R10 cur cleared", 3, 0);
        expect_out("R10 prev cleared", 4, 0);
        next_cycle(); irq_switch = 1; irq_set = 1; settle();
        next_cycle(); settle();
        expect_out("R10 set1 cleared", 0, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule